// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Interrupt

This block holds received characters between the deserializer and the data register of a UART. Each stored entry is 12 bits wide: an 8-bit character and four per-character error flags. Characters arrive on a push port, from the line receiver or from an internal loopback source. A read of the data register pops the oldest entry. The block drives the empty and full flags, a receive interrupt level and a free-slot count that the source uses for backpressure.

At run time a mode input selects between a 16-deep queue and a single holding register. Any change of that input empties the buffer. The receive interrupt uses a fixed trigger count of one. It is raised only by the push that brings the occupancy to one, and lowered only by a pop that leaves the buffer empty. Every pop also copies the popped entry's error flags into a separate status register, which software can clear.

Top module: `uart_rx_buffer`

## Requirements
- R1: With `fifo_en`=1 the buffer holds up to 16 entries and returns them in push order. With `fifo_en`=0 it holds exactly one entry.
- R2: `rx_empty` is 1 after reset. A stored push clears it, and a pop that brings the occupancy to 0 sets it.
- R3: `rx_full` is set when a push makes the occupancy equal to the current depth. Every pop clears it, unless a push in the same cycle fills the buffer again.
- R4: `pop_data` shows the oldest entry, unchanged. Bits [7:0] hold the character, bit 8 a framing error, bit 9 a parity error, bit 10 a break and bit 11 an overrun. A break entry has the value 0x400.
- R5: `rx_irq` is set when a push leaves the occupancy at 1. It is cleared when a pop leaves the occupancy at 0, and this includes a pop on an already empty buffer.
- R6: In a cycle where `fifo_en` differs from the mode in force, the occupancy and head are cleared, `rx_empty` is set and `rx_full` is cleared. A push or pop in that cycle is ignored, and `rx_irq` keeps its value.
- R7: A pop copies bits [11:8] of the popped entry into `rx_status`. A `status_clear` pulse sets `rx_status` to 0, and the clear takes priority over a pop in the same cycle.
- R8: `free_space` equals the current depth minus the occupancy.
- R9: A pop on an empty buffer leaves the occupancy and the head unchanged, so `pop_data` still shows the entry at the head.
- R10: A push into a full buffer is dropped. The next entry that is stored has bit 11 (overrun) set.
- R11: When a push and a pop occur in the same cycle, the pop is applied first. A push arriving while the buffer is full is then stored and does not count as an overrun.
- R12: After reset the block is in single-entry mode, with `rx_irq`=0, `rx_status`=0, `rx_full`=0, `free_space`=1 and `pop_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects the 16-deep queue, 0 selects the single holding register |
| push_valid | input | 1 | Entry offered on push_data this cycle |
| push_data | input | 12 | Entry to store: character plus error flags |
| pop | input | 1 | Data-register read; removes the head entry |
| status_clear | input | 1 | Write to the status register; clears rx_status |
| pop_data | output | 12 | Entry at the head of the buffer |
| rx_status | output | 4 | Error flags of the last popped entry |
| rx_empty | output | 1 | Buffer empty flag |
| rx_full | output | 1 | Buffer full flag |
| rx_irq | output | 1 | Receive interrupt level |
| free_space | output | 5 | Depth minus occupancy |

## Verification
A wrong occupancy or head pointer appears at `pop_data` on the next read: the bench's scoreboard then sees a reordered, repeated or stale entry. It also appears at `free_space` and at the flags in the cycle after the bad update. A lost overrun marker or a wrong error capture shows up in bit 11 of the next stored entry, or in `rx_status` one cycle after the pop. A mode switch that fails to flush leaves old entries that the first read after the switch exposes. Because the interrupt is driven by equality, a miscounted occupancy leaves `rx_irq` stuck in one state until the next transition to empty.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    localparam int CHAR_W  = 8;
    localparam int ERR_W   = 4;
    localparam int ENTRY_W = CHAR_W + ERR_W;
    localparam int OVR_BIT = 11;
    localparam int RX_TRIG = 1;
    typedef logic [ENTRY_W-1:0] rx_entry_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  rx_entry_t        wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output rx_entry_t        rd_data
);
    rx_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rx_entry_t slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && wr_idx == PTR_W'(g)) slot_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_valid,
    input  rx_entry_t        push_data,
    input  logic             pop,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output rx_entry_t        wr_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             pop_take,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_irq,
    output logic [CNT_W-1:0] free_space
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             full;
        logic             irq;
        logic             ovr;
        logic             fen;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [PTR_W-1:0] mask_w;
    logic [CNT_W-1:0] depth_w;

    always_comb begin
        mask_w   = st_q.fen ? PTR_W'(DEPTH - 1) : '0;
        depth_w  = st_q.fen ? CNT_W'(DEPTH) : CNT_W'(1);
        st_d     = st_q;
        wr_en    = 1'b0;
        wr_idx   = '0;
        wr_data  = push_data;
        pop_take = 1'b0;
        if (fifo_en != st_q.fen) begin
            st_d.fen   = fifo_en;
            st_d.head  = '0;
            st_d.cnt   = '0;
            st_d.empty = 1'b1;
            st_d.full  = 1'b0;
            st_d.ovr   = 1'b0;
        end else begin
            if (pop) begin
                pop_take  = 1'b1;
                st_d.full = 1'b0;
                if (st_q.cnt != '0) begin
                    st_d.cnt  = st_q.cnt - 1'b1;
                    st_d.head = (st_q.head + 1'b1) & mask_w;
                end
                if (st_d.cnt == '0) begin
                    st_d.empty = 1'b1;
                    st_d.irq   = 1'b0;
                end
            end
            if (push_valid) begin
                if (st_d.cnt == depth_w) begin
                    st_d.ovr = 1'b1;
                end else begin
                    wr_en  = 1'b1;
                    wr_idx = (st_d.head + st_d.cnt[PTR_W-1:0]) & mask_w;
                    if (st_q.ovr) wr_data[OVR_BIT] = 1'b1;
                    st_d.ovr   = 1'b0;
                    st_d.cnt   = st_d.cnt + 1'b1;
                    st_d.empty = 1'b0;
                    if (st_d.cnt == depth_w)        st_d.full = 1'b1;
                    if (st_d.cnt == CNT_W'(RX_TRIG)) st_d.irq  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx     = st_q.head;
    assign rx_empty   = st_q.empty;
    assign rx_full    = st_q.full;
    assign rx_irq     = st_q.irq;
    assign free_space = depth_w - st_q.cnt;

    a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= depth_w);
    a_r2_empty_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.empty == (st_q.cnt == '0));
    a_r3_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full == (st_q.cnt == depth_w));
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop && st_q.cnt == '0 && fifo_en == st_q.fen) |=> rx_irq);
    a_r6_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != st_q.fen) |=> (rx_empty && !rx_full && $stable(rx_irq)));
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop && rx_full && fifo_en == st_q.fen) |=> rx_full);
endmodule

// File: rtl/rxb_errstat.sv
module rxb_errstat
    import uart_rxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [ERR_W-1:0] err_in,
    input  logic             clear,
    output logic [ERR_W-1:0] status
);
    logic [ERR_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (capture) stat_d = err_in;
        if (clear)   stat_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (status == '0));
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear) |=> (status == $past(err_in)));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    input  logic               status_clear,
    output logic [ENTRY_W-1:0] pop_data,
    output logic [ERR_W-1:0]   rx_status,
    output logic               rx_empty,
    output logic               rx_full,
    output logic               rx_irq,
    output logic [CNT_W-1:0]   free_space
);
    logic             wr_en_w;
    logic [PTR_W-1:0] wr_idx_w;
    rx_entry_t        wr_data_w;
    logic [PTR_W-1:0] rd_idx_w;
    logic             pop_take_w;
    rx_entry_t        head_w;

    rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop        (pop),
        .wr_en      (wr_en_w),
        .wr_idx     (wr_idx_w),
        .wr_data    (wr_data_w),
        .rd_idx     (rd_idx_w),
        .pop_take   (pop_take_w),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .rx_irq     (rx_irq),
        .free_space (free_space)
    );

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (wr_data_w),
        .rd_idx  (rd_idx_w),
        .rd_data (head_w)
    );

    rxb_errstat u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (pop_take_w),
        .err_in  (head_w[ENTRY_W-1:CHAR_W]),
        .clear   (status_clear),
        .status  (rx_status)
    );

    assign pop_data = head_w;

    a_r9_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_valid && rx_empty && $stable(fifo_en)) |=> $stable(pop_data));
endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_valid = 1'b0;
    logic [11:0] push_data = '0;
    logic        pop = 1'b0;
    logic        status_clear = 1'b0;
    logic [11:0] pop_data;
    logic [3:0]  rx_status;
    logic        rx_empty, rx_full, rx_irq;
    logic [4:0]  free_space;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] sb[$];
    logic [11:0] last_head = '0;
    logic        m_ovr = 1'b0;
    int          m_depth = 1;

    always #4 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
        .push_data(push_data), .pop(pop), .status_clear(status_clear),
        .pop_data(pop_data), .rx_status(rx_status), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_irq(rx_irq), .free_space(free_space)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [11:0] v);
        if (sb.size() < m_depth) begin
            sb.push_back(m_ovr ? (v | 12'h800) : v);
            m_ovr = 1'b0;
        end else begin
            m_ovr = 1'b1;
        end
    endtask

    task automatic push_in(input logic [11:0] v);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = v;
        @(negedge clk);
        push_valid = 1'b0;
        model_push(v);
    endtask

    // scoreboard monitor: compares the head against the expected queue, then pops
    task automatic pop_chk(input string req);
        logic [11:0] exp;
        exp = (sb.size() != 0) ? sb[0] : last_head;
        @(negedge clk);
        check(req, pop_data, exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check({req, " R7 status"}, rx_status, exp[11:8]);
        if (sb.size() != 0) last_head = sb.pop_front();
    endtask

    task automatic push_pop(input logic [11:0] v);
        @(negedge clk);
        check("R11 head", pop_data, sb[0]);
        push_valid = 1'b1;
        push_data  = v;
        pop        = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
        pop        = 1'b0;
        last_head = sb.pop_front();
        model_push(v);
    endtask

    task automatic set_mode(input logic en);
        @(negedge clk);
        fifo_en = en;
        @(negedge clk);
        sb.delete();
        m_ovr   = 1'b0;
        m_depth = en ? 16 : 1;
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 empty", rx_empty, 1);
        check("R12 full", rx_full, 0);
        check("R12 irq", rx_irq, 0);
        check("R12 status", rx_status, 0);
        check("R12 free", free_space, 1);
        check("R12 head", pop_data, 0);

        // character mode: R1 R2 R3 R5 R8
        push_in(12'h041);
        check("R2 empty cleared", rx_empty, 0);
        check("R3 full char mode", rx_full, 1);
        check("R5 irq set", rx_irq, 1);
        check("R8 free zero", free_space, 0);
        push_in(12'h042);                       // R10 dropped
        check("R10 still full", rx_full, 1);
        pop_chk("R4 char head");
        check("R2 empty set", rx_empty, 1);
        check("R3 full cleared", rx_full, 0);
        check("R5 irq cleared", rx_irq, 0);
        pop_chk("R9 empty pop");
        check("R9 free", free_space, 1);
        check("R9 empty", rx_empty, 1);
        push_in(12'h043);
        pop_chk("R10 overrun marked");
        @(negedge clk); status_clear = 1'b1;
        @(negedge clk); status_clear = 1'b0;
        check("R7 cleared", rx_status, 0);

        // FIFO mode: R1 R4 R8 R3
        set_mode(1'b1);
        check("R1 free 16", free_space, 16);
        check("R6 empty after switch", rx_empty, 1);
        for (int i = 0; i < 16; i++) begin
            if (i == 5) push_in(12'h400);
            else        push_in(12'((i << 8) | (8'h30 + i)));
            if (i == 1) check("R5 irq held", rx_irq, 1);
        end
        check("R3 full fifo", rx_full, 1);
        check("R8 free 0", free_space, 0);
        for (int i = 0; i < 16; i++) begin
            pop_chk("R1 order");
            if (i == 14) check("R5 irq kept one left", rx_irq, 1);
        end
        check("R5 irq cleared fifo", rx_irq, 0);

        // simultaneous push and pop while full: R11
        for (int i = 0; i < 16; i++) push_in(12'(8'h60 + i));
        push_pop(12'h0AA);
        check("R11 full kept", rx_full, 1);
        for (int i = 0; i < 16; i++) pop_chk("R11 no overrun");

        // mode change with data: R6, then empty pop clears irq (R5)
        push_in(12'h011); push_in(12'h022); push_in(12'h033);
        set_mode(1'b0);
        check("R6 empty", rx_empty, 1);
        check("R6 full", rx_full, 0);
        check("R6 free", free_space, 1);
        check("R6 irq kept", rx_irq, 1);
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
        check("R5 empty pop clears irq", rx_irq, 0);

        // clear has priority over pop capture: R7
        push_in(12'h155);
        @(negedge clk); pop = 1'b1; status_clear = 1'b1;
        @(negedge clk); pop = 1'b0; status_clear = 1'b0;
        check("R7 clear wins", rx_status, 0);
        check("R2 empty after pop", rx_empty, 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule